// File: doc/BRIEF.md
# Packed Opcode Slot Sequencer

This block sits at the front of a small stack-machine core. It keeps one fetched instruction word and hands out, one per clock, the short opcodes packed inside it. A 16-bit word carries three 5-bit opcodes. Before the three slots come round, the sequencer spends one cycle presenting a fixed fetch opcode. The decoder downstream answers that cycle by raising the load strobe, which captures the next word from memory.

A run of plain stack operations therefore costs one memory access for every three opcodes. Any control transfer (jump, conditional jump, call or return) raises the restart strobe. The next cycle then begins again at the fetch position, so the word at the new program address is the one that gets loaded. The sequencer also exports the low ten bits of the held word as a short on-page branch argument. It joins them with the current page bits of the program counter to form a complete branch address. Executing the opcodes is left to the surrounding core.

Top module: `slot_sequencer`

## Requirements
- R1: While `clr_n` is low, and immediately after it falls, the slot index is 0, the held word is all zeros, `opcode_o` is 5'b01000 and `target_o` is 0.
- R2: With `restart_i` low, the slot index steps by one on each rising clock edge through 0, 1, 2, 3 and then wraps from 3 back to 0.
- R3: With `restart_i` high at a rising edge, the slot index is 0 after that edge, whatever slot was current and whatever `load_i` is.
- R4: In slot 0, `opcode_o` is the fetch code 5'b01000, whatever word is held.
- R5: In slots 1, 2 and 3, `opcode_o` equals bits 15..11, 10..6 and 5..1 of the held word respectively. Bit 0 never reaches `opcode_o`.
- R6: With `load_i` high at a rising edge, the held word becomes `mem_data_i`. With `load_i` low, the held word is unchanged however `mem_data_i` moves.
- R7: `target_o` equals bits 9..0 of the held word.
- R8: `branch_addr_o` is `page_i` in bits 15..10 and `target_o` in bits 9..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_i | input | 1 | Capture `mem_data_i` into the held word |
| restart_i | input | 1 | Return the slot index to 0 at the next edge |
| mem_data_i | input | 16 | Word read from memory |
| page_i | input | 6 | Upper program-counter bits for the branch address |
| opcode_o | output | 5 | Opcode of the current slot |
| slot_o | output | 2 | Current slot index |
| target_o | output | 10 | Short on-page branch argument |
| branch_addr_o | output | 16 | Page bits joined with the branch argument |

## Verification
The case that is hardest to reach from the ports is a restart landing on each of the four slot positions, including one that coincides with a load. A restart normally arrives only after some chosen number of free-running steps. The stimulus therefore counts slots in its own model until the wanted position comes up, and only then raises restart, with and without load. Field selection is swept with words built so that every 5-bit code appears in every slot. Load-hold is checked by moving `mem_data_i` freely while `load_i` stays low and watching the opcodes and branch argument stay on the old word.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;

    // Opcode presented in the fetch slot (slot 0).
    localparam logic [4:0] FETCH_CODE = 5'b01000;

    // Lowest bit of the opcode field for packed slot k (k counts from 1).
    function automatic int field_lsb(input int word_w, input int op_w, input int k);
        return word_w - k * op_w;
    endfunction

endpackage

// File: rtl/slotseq_counter.sv
module slotseq_counter #(
    parameter int OPS_PER_WORD = 3,
    parameter int SLOT_W       = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              restart_i,
    output logic [SLOT_W-1:0] slot_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(OPS_PER_WORD);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d.slot = '0;
        end else if (state_q.slot == LAST_SLOT) begin
            state_d.slot = '0;
        end else begin
            state_d.slot = state_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign slot_o = state_q.slot;

endmodule

// File: rtl/slotseq_ireg.sv
module slotseq_ireg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } ir_state_t;

    ir_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.word = data_i;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o = state_q.word;

endmodule

// File: rtl/slotseq_opsel.sv
module slotseq_opsel #(
    parameter int              OP_W         = 5,
    parameter int              OPS_PER_WORD = 3,
    parameter int              SLOT_W       = 2,
    parameter logic [OP_W-1:0] FETCH        = slotseq_pkg::FETCH_CODE
) (
    input  logic [OPS_PER_WORD*OP_W-1:0] fields_i,
    input  logic [SLOT_W-1:0]            slot_i,
    output logic [OP_W-1:0]              opcode_o
);
    localparam int PACK_W = OPS_PER_WORD * OP_W;

    logic [OP_W-1:0] field [OPS_PER_WORD+1];

    assign field[0] = FETCH;

    for (genvar k = 1; k <= OPS_PER_WORD; k++) begin : g_field
        localparam int LSB = slotseq_pkg::field_lsb(PACK_W, OP_W, k);
        assign field[k] = fields_i[LSB +: OP_W];
    end

    always_comb begin
        opcode_o = FETCH;
        for (int k = 1; k <= OPS_PER_WORD; k++) begin
            if (slot_i == SLOT_W'(k)) begin
                opcode_o = field[k];
            end
        end
    end

endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
    parameter int WORD_W       = 16,
    parameter int OP_W         = 5,
    parameter int OPS_PER_WORD = 3,
    parameter int ARG_W        = 10,
    parameter int ADDR_W       = 16,
    localparam int SLOT_W      = $clog2(OPS_PER_WORD + 1),
    localparam int PAGE_W      = ADDR_W - ARG_W
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              load_i,
    input  logic              restart_i,
    input  logic [WORD_W-1:0] mem_data_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic [OP_W-1:0]   opcode_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [ARG_W-1:0]  target_o,
    output logic [ADDR_W-1:0] branch_addr_o
);
    localparam int PACK_W = OPS_PER_WORD * OP_W;

    logic [WORD_W-1:0] word_q;
    logic [SLOT_W-1:0] slot_q;

    slotseq_counter #(
        .OPS_PER_WORD(OPS_PER_WORD),
        .SLOT_W      (SLOT_W)
    ) u_counter (
        .clk      (clk),
        .clr_n    (clr_n),
        .restart_i(restart_i),
        .slot_o   (slot_q)
    );

    slotseq_ireg #(
        .WORD_W(WORD_W)
    ) u_ireg (
        .clk   (clk),
        .clr_n (clr_n),
        .load_i(load_i),
        .data_i(mem_data_i),
        .word_o(word_q)
    );

    slotseq_opsel #(
        .OP_W        (OP_W),
        .OPS_PER_WORD(OPS_PER_WORD),
        .SLOT_W      (SLOT_W),
        .FETCH       (slotseq_pkg::FETCH_CODE)
    ) u_opsel (
        .fields_i(word_q[WORD_W-1 -: PACK_W]),
        .slot_i  (slot_q),
        .opcode_o(opcode_o)
    );

    assign slot_o        = slot_q;
    assign target_o      = word_q[ARG_W-1:0];
    assign branch_addr_o = {page_i, word_q[ARG_W-1:0]};

endmodule

// File: rtl/slotseq_checker.sv
module slotseq_checker #(
    parameter int WORD_W       = 16,
    parameter int OP_W         = 5,
    parameter int OPS_PER_WORD = 3,
    parameter int ARG_W        = 10,
    parameter int SLOT_W       = 2
) (
    input logic              clk,
    input logic              clr_n,
    input logic              load_i,
    input logic              restart_i,
    input logic [WORD_W-1:0] mem_data_i,
    input logic [OP_W-1:0]   opcode_o,
    input logic [SLOT_W-1:0] slot_o,
    input logic [ARG_W-1:0]  target_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(OPS_PER_WORD);

    // R3
    restart_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        restart_i |=> slot_o == '0);

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !restart_i |=> slot_o == (($past(slot_o) == LAST_SLOT) ? '0 : $past(slot_o) + 1'b1));

    // R4
    fetch_slot_chk: assert property (@(posedge clk) disable iff (!clr_n)
        slot_o == '0 |-> opcode_o == slotseq_pkg::FETCH_CODE);

    // R6
    load_first_field_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_i && !restart_i && slot_o == '0) |=> opcode_o == $past(mem_data_i[WORD_W-1 -: OP_W]));

    // R7
    target_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_i |=> $stable(target_o));

endmodule

bind slot_sequencer slotseq_checker #(
    .WORD_W      (WORD_W),
    .OP_W        (OP_W),
    .OPS_PER_WORD(OPS_PER_WORD),
    .ARG_W       (ARG_W),
    .SLOT_W      (SLOT_W)
) u_slotseq_checker (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_i    (load_i),
    .restart_i (restart_i),
    .mem_data_i(mem_data_i),
    .opcode_o  (opcode_o),
    .slot_o    (slot_o),
    .target_o  (target_o)
);

// File: tb/test_slot_sequencer.sv
`timescale 1ns/1ps
module test_slot_sequencer;
    logic        clk = 1'b0;
    logic        clr_n;
    logic        load_i;
    logic        restart_i;
    logic [15:0] mem_data_i;
    logic [5:0]  page_i;
    logic [4:0]  opcode_o;
    logic [1:0]  slot_o;
    logic [9:0]  target_o;
    logic [15:0] branch_addr_o;

    always #10 clk = ~clk;

    slot_sequencer i_slot_sequencer (
        .clk          (clk),
        .clr_n        (clr_n),
        .load_i       (load_i),
        .restart_i    (restart_i),
        .mem_data_i   (mem_data_i),
        .page_i       (page_i),
        .opcode_o     (opcode_o),
        .slot_o       (slot_o),
        .target_o     (target_o),
        .branch_addr_o(branch_addr_o)
    );

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    int          exp_slot;
    logic [15:0] exp_word;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_op(input int s, input logic [15:0] w);
        if (s == 0) return 8;
        return int'((w >> (16 - 5 * s)) & 16'h001f);
    endfunction

    task automatic check_all();
        chk("R2/R3 slot", int'(slot_o), exp_slot);
        if (exp_slot == 0) chk("R4 fetch opcode", int'(opcode_o), 8);
        else               chk("R5 slot opcode", int'(opcode_o), exp_op(exp_slot, exp_word));
        chk("R7 target", int'(target_o), int'(exp_word & 16'h03ff));
        chk("R8 branch", int'(branch_addr_o), int'({page_i, exp_word[9:0]}));
    endtask

    task automatic cycle(input logic ld, input logic rs, input logic [15:0] d, input logic [5:0] pg);
        load_i     = ld;
        restart_i  = rs;
        mem_data_i = d;
        page_i     = pg;
        @(posedge clk);
        #2;
        if (ld) exp_word = d;
        if (rs) exp_slot = 0;
        else    exp_slot = (exp_slot == 3) ? 0 : exp_slot + 1;
        load_i    = 1'b0;
        restart_i = 1'b0;
        #1;
        check_all();
    endtask

    task automatic do_clear();
        #3;
        clr_n = 1'b0;
        #1;
        exp_slot = 0;
        exp_word = '0;
        chk("R1 slot after clear", int'(slot_o), 0);
        chk("R1 opcode after clear", int'(opcode_o), 8);
        chk("R1 target after clear", int'(target_o), 0);
        @(posedge clk);
        #2;
        clr_n = 1'b1;
    endtask

    initial begin
        clr_n      = 1'b0;
        load_i     = 1'b0;
        restart_i  = 1'b0;
        mem_data_i = '0;
        page_i     = '0;
        exp_slot   = 0;
        exp_word   = '0;
        #1;
        chk("R1 reset slot", int'(slot_o), 0);
        chk("R1 reset opcode", int'(opcode_o), 8);
        chk("R1 reset target", int'(target_o), 0);
        repeat (2) @(posedge clk);
        #2;
        clr_n = 1'b1;

        // R5 sweep: every 5-bit code in every slot, loaded in the fetch slot.
        for (int w = 0; w < 64; w++) begin
            logic [15:0] word;
            word = {5'(w), 5'(w + 11), 5'(w * 3 + 5), 1'(w >> 1)};
            while (exp_slot != 0) cycle(1'b0, 1'b0, 16'hdead, 6'(w));
            cycle(1'b1, 1'b0, word, 6'(w));
            for (int s = 0; s < 3; s++) cycle(1'b0, 1'b0, ~word, 6'(w + s));
        end

        // R6: bit 0 toggling alone never changes the opcodes (R5).
        cycle(1'b1, 1'b0, 16'h0001, 6'h3f);
        for (int s = 0; s < 4; s++) cycle(1'b0, 1'b0, 16'hffff, 6'h15);

        // R3: restart at each slot position, with and without load.
        for (int pos = 0; pos < 4; pos++) begin
            for (int ld = 0; ld < 2; ld++) begin
                while (exp_slot != pos) cycle(1'b0, 1'b0, 16'h1234, 6'h2a);
                cycle(1'(ld), 1'b1, 16'(16'hc3a5 ^ (pos * 4 + ld)), 6'h2a);
                chk("R3 restart to slot 0", int'(slot_o), 0);
            end
        end

        // R6 hold over many cycles with moving data, pseudo-random words.
        for (int w = 0; w < 200; w++) begin
            logic [15:0] word;
            word = 16'(w * 40503 + 12345);
            cycle(1'b1, 1'(w % 7 == 3), word, 6'(w * 5));
            for (int s = 0; s < (w % 5); s++) cycle(1'b0, 1'b0, 16'(~word + s), 6'(w));
        end

        // R2: free run through several wraps.
        for (int s = 0; s < 12; s++) cycle(1'b0, 1'b0, 16'(s), 6'(s));

        // R1: asynchronous clear in the middle of a run.
        cycle(1'b1, 1'b0, 16'hbeef, 6'h01);
        do_clear();
        for (int s = 0; s < 4; s++) cycle(1'b0, 1'b0, 16'h7777, 6'h02);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule